// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block is the timing controller for a measurement engine that serves up to four sensor channels. Each reference-clock cycle is one tick of its counters. For every channel it visits, it runs three phases in a fixed order. First comes a settling window, in which the sensor oscillation stabilises. Next comes a conversion window, in which the engine measures. Last comes a switch gap, in which nothing is enabled. The length of each phase comes from per-channel programmed counts.

Two modes are available. In single-channel mode, conversions repeat without end on one selected channel. In round-robin mode, the block walks upward through an encoded set of channels and wraps back to channel 0. It tells the engine which channel is active and which window is open. It pulses a strobe together with the channel number on the last conversion cycle. A sticky data-ready flag marks a finished pass, and the host clears it with a pulse. Configuration inputs are sampled only when a new channel dwell starts. Changes made mid-dwell therefore never cut a phase short.

Top module: `conv_sequencer`

## Requirements
- R1: When `autoscan_en` is 0, every dwell uses the channel given by `single_sel` (00 = ch0, 01 = ch1, 10 = ch2, 11 = ch3), and conversions on that channel repeat without end.
- R2: When `autoscan_en` is 1, channels run in ascending order and wrap to ch0. `seq_code` 00 visits ch0,ch1, 01 visits ch0..ch2 and 10 visits ch0..ch3. The first dwell after a start is always ch0.
- R3: `seq_code` 11 behaves exactly like 10, so all four channels are visited.
- R4: For channel x, `settle_en` is high for S×16 consecutive cycles. S is the 16-bit field `settle_counts[16x+15:16x]`. When S is 0 the settling phase is skipped. `settle_en` and `conv_en` are never high together.
- R5: For channel x, `conv_en` is high for R×16+4 consecutive cycles. R is the 16-bit field `conv_counts[16x+15:16x]`.
- R6: After each conversion there is a switch gap of SW_FIXED+5 cycles, with neither enable high, before the next dwell starts. SW_FIXED defaults to 8.
- R7: `eoc_pulse` is high for exactly the last cycle of each conversion window, and `eoc_chan` gives that dwell's channel.
- R8: `drdy` rises on the cycle after an end of conversion that is the last channel of a round-robin pass, or after any end of conversion in single-channel mode. It holds until a `drdy_clr` cycle with no setting event in that same cycle. If both happen in the same cycle, the set wins.
- R9: While `enable` is low the block is idle: `settle_en`, `conv_en` and `eoc_pulse` are low and `chan_idx` is 0. A new start begins with a fresh dwell.
- R10: Mode, channel selection, sequence code and both counts are taken only when a dwell starts. Changes during a dwell affect only the next dwell.
- R11: After a synchronous reset (`rst_n` low at a clock edge), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle is one count |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run when high, idle when low |
| autoscan_en | input | 1 | 0 = single channel, 1 = round-robin |
| seq_code | input | 2 | Round-robin channel set code |
| single_sel | input | 2 | Channel used in single-channel mode |
| settle_counts | input | 64 | Four 16-bit settling counts, ch x at bits 16x+15:16x |
| conv_counts | input | 64 | Four 16-bit conversion counts, ch x at bits 16x+15:16x |
| drdy_clr | input | 1 | Host clear pulse for the data-ready flag |
| chan_idx | output | 2 | Channel of the current dwell |
| settle_en | output | 1 | Settling window open |
| conv_en | output | 1 | Conversion window open |
| eoc_pulse | output | 1 | Last cycle of a conversion |
| eoc_chan | output | 2 | Channel that the end-of-conversion strobe belongs to |
| drdy | output | 1 | Sticky data-ready flag |

## Verification
The hardest case to reach from the ports is a configuration change that lands in the middle of a dwell. Its effect must stay hidden until the switch gap ends. The stimulus therefore waits until the settling window of a single-channel dwell is visibly open, and only then retargets `single_sel`. The scoreboard expects the current conversion to finish on the old channel with the old timing, and the following ones on the new channel. A second hard case is a partly finished round-robin pass cut off by `enable`. This case is reached by dropping `enable` after the first end of conversion and checking that the restart begins again at ch0. The zero-settle channel is part of every four-channel pass, so the skipped-phase path runs under round-robin traffic.

// File: rtl/seqr_pkg.sv
// Shared types and helpers for the conversion sequencer.
// Assumes at most four channels, with 2-bit channel indices.
package seqr_pkg;
    localparam int SEQ_NCH = 4;
    localparam int SEQ_CHW = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_CONV   = 2'd2,
        PH_SWITCH = 2'd3
    } phase_e;

    // Highest channel index of a round-robin pass; code 11 acts as 10.
    function automatic logic [SEQ_CHW-1:0] rr_last(input logic [1:0] code);
        case (code)
            2'b00:   return 2'd1;
            2'b01:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/seqr_chan_pick.sv
// Works out the channel of the next dwell.
// Assumes cur is the channel of the dwell now ending, and restart is high
// when the block leaves idle, so that a pass starts at channel 0.
module seqr_chan_pick
    import seqr_pkg::*;
(
    input  logic [SEQ_CHW-1:0] cur,
    input  logic               restart,
    input  logic               autoscan,
    input  logic [1:0]         seq_code,
    input  logic [SEQ_CHW-1:0] single_sel,
    output logic [SEQ_CHW-1:0] nxt,
    output logic [SEQ_CHW-1:0] last_idx
);
    // Picks the next channel: the fixed channel, or ascending with wrap.
    always_comb begin
        last_idx = rr_last(seq_code);
        if (!autoscan)
            nxt = single_sel;
        else if (restart || (cur >= last_idx))
            nxt = '0;
        else
            nxt = cur + 1'b1;
    end
endmodule

// File: rtl/seqr_len_sel.sv
// Turns the per-channel programmed counts of one selected channel into
// phase lengths in reference cycles: settle = S*16, convert = R*16+4.
// Assumes each channel's counts are packed at [x*CNT_W +: CNT_W].
module seqr_len_sel
    import seqr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = CNT_W + 5
) (
    input  logic [SEQ_NCH*CNT_W-1:0] settle_flat,
    input  logic [SEQ_NCH*CNT_W-1:0] conv_flat,
    input  logic [SEQ_CHW-1:0]       sel,
    output logic [LEN_W-1:0]         settle_len,
    output logic [LEN_W-1:0]         conv_len
);
    logic [CNT_W-1:0] s_arr [SEQ_NCH];
    logic [CNT_W-1:0] r_arr [SEQ_NCH];

    for (genvar g = 0; g < SEQ_NCH; g++) begin : g_unpack
        assign s_arr[g] = settle_flat[g*CNT_W +: CNT_W];
        assign r_arr[g] = conv_flat[g*CNT_W +: CNT_W];
    end

    // Scales the selected counts into cycle lengths.
    always_comb begin
        settle_len = LEN_W'({s_arr[sel], 4'b0000});
        conv_len   = LEN_W'({r_arr[sel], 4'b0000}) + LEN_W'(4);
    end
endmodule

// File: rtl/seqr_phase_ctl.sv
// Phase state machine with one shared down-counter. Each dwell runs
// settle (skipped when its length is 0), then convert, then the switch
// gap. The channel, the conversion length and the mode are latched at
// the start of a dwell. Assumes conv_len_in is at least 4.
module seqr_phase_ctl
    import seqr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SW_FIXED = 8,
    parameter int LEN_W    = CNT_W + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [LEN_W-1:0]   settle_len_in,
    input  logic [LEN_W-1:0]   conv_len_in,
    input  logic               auto_in,
    input  logic [SEQ_CHW-1:0] last_in,
    input  logic [SEQ_CHW-1:0] nxt_chan,
    output phase_e             phase,
    output logic [SEQ_CHW-1:0] chan,
    output logic               is_idle,
    output logic               eoc,
    output logic               pass_done
);
    localparam int SW_LEN = SW_FIXED + 5;
    localparam logic [LEN_W-1:0] SW_LOAD = LEN_W'(SW_LEN - 1);

    logic [LEN_W-1:0]   cnt;
    logic [LEN_W-1:0]   conv_len_q;
    logic               auto_q;
    logic [SEQ_CHW-1:0] last_q;
    logic               boundary;

    // A new dwell starts when leaving idle or at the end of the switch gap.
    always_comb begin
        is_idle   = (phase == PH_IDLE);
        boundary  = is_idle || ((phase == PH_SWITCH) && (cnt == '0));
        eoc       = (phase == PH_CONV) && (cnt == '0);
        pass_done = eoc && (!auto_q || (chan == last_q));
    end

    // Steps the phases and reloads the counter at each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            chan       <= '0;
            conv_len_q <= '0;
            auto_q     <= 1'b0;
            last_q     <= '0;
        end else if (boundary) begin
            chan       <= nxt_chan;
            conv_len_q <= conv_len_in;
            auto_q     <= auto_in;
            last_q     <= last_in;
            if (settle_len_in == '0) begin
                phase <= PH_CONV;
                cnt   <= conv_len_in - 1'b1;
            end else begin
                phase <= PH_SETTLE;
                cnt   <= settle_len_in - 1'b1;
            end
        end else begin
            case (phase)
                PH_SETTLE: begin
                    if (cnt == '0) begin
                        phase <= PH_CONV;
                        cnt   <= conv_len_q - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_CONV: begin
                    if (cnt == '0) begin
                        phase <= PH_SWITCH;
                        cnt   <= SW_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: cnt <= cnt - 1'b1;
            endcase
        end
    end

    // R5: the conversion counter stays below the latched conversion length.
    p_conv_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV) |-> (cnt < conv_len_q));

    // R6: the switch gap does not end before its counter reaches zero.
    p_switch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (phase == PH_SWITCH) && (cnt != '0)) |=> (!enable || (phase == PH_SWITCH)));

    // R10: the channel only moves at a dwell boundary.
    p_chan_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(rst_n) && ($past(phase) != PH_IDLE) && !$past(boundary))
            |-> (chan == $past(chan)));
endmodule

// File: rtl/conv_sequencer.sv
// Top of the multi-channel conversion sequencer. It connects the
// channel picker, the length selector and the phase controller, and
// keeps the sticky data-ready flag. Assumes a single reference clock
// domain and that host inputs are already synchronous to it.
module conv_sequencer
    import seqr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SW_FIXED = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     autoscan_en,
    input  logic [1:0]               seq_code,
    input  logic [1:0]               single_sel,
    input  logic [SEQ_NCH*CNT_W-1:0] settle_counts,
    input  logic [SEQ_NCH*CNT_W-1:0] conv_counts,
    input  logic                     drdy_clr,
    output logic [1:0]               chan_idx,
    output logic                     settle_en,
    output logic                     conv_en,
    output logic                     eoc_pulse,
    output logic [1:0]               eoc_chan,
    output logic                     drdy
);
    localparam int LEN_W = CNT_W + 5;

    logic [SEQ_CHW-1:0] nxt_chan;
    logic [SEQ_CHW-1:0] last_idx;
    logic [SEQ_CHW-1:0] cur_chan;
    logic [LEN_W-1:0]   settle_len;
    logic [LEN_W-1:0]   conv_len;
    logic               idle;
    logic               pass_done;
    phase_e             phase;

    seqr_chan_pick u_pick (
        .cur        (cur_chan),
        .restart    (idle),
        .autoscan   (autoscan_en),
        .seq_code   (seq_code),
        .single_sel (single_sel),
        .nxt        (nxt_chan),
        .last_idx   (last_idx)
    );

    seqr_len_sel #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_len (
        .settle_flat (settle_counts),
        .conv_flat   (conv_counts),
        .sel         (nxt_chan),
        .settle_len  (settle_len),
        .conv_len    (conv_len)
    );

    seqr_phase_ctl #(.CNT_W(CNT_W), .SW_FIXED(SW_FIXED), .LEN_W(LEN_W)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .settle_len_in (settle_len),
        .conv_len_in   (conv_len),
        .auto_in       (autoscan_en),
        .last_in       (last_idx),
        .nxt_chan      (nxt_chan),
        .phase         (phase),
        .chan          (cur_chan),
        .is_idle       (idle),
        .eoc           (eoc_pulse),
        .pass_done     (pass_done)
    );

    // Decodes the phase into the window enables and the channel outputs.
    always_comb begin
        settle_en = (phase == PH_SETTLE);
        conv_en   = (phase == PH_CONV);
        chan_idx  = cur_chan;
        eoc_chan  = cur_chan;
    end

    // Sticky data-ready flag: a pass end sets it, a host pulse clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drdy <= 1'b0;
        else if (pass_done)
            drdy <= 1'b1;
        else if (drdy_clr)
            drdy <= 1'b0;
    end

    // R4: the two windows never overlap.
    p_one_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(settle_en && conv_en));

    // R7: the strobe only appears inside the conversion window.
    p_eoc_in_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_pulse |-> (conv_en && !settle_en));

    // R8: a clear with no strobe in the same cycle empties the flag.
    p_drdy_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_clr && !eoc_pulse) |=> !drdy);

    // R8: without a clear the flag stays set.
    p_drdy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy && !drdy_clr) |=> drdy);

    // R9: disabling returns the block to idle on the next cycle.
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!settle_en && !conv_en && !eoc_pulse && (chan_idx == 2'd0)));
endmodule

// File: tb/test_conv_sequencer.sv
// Scoreboard bench: a driver task queues expected end-of-conversion events,
// and a monitor pops and compares them as the design produces them.
module test_conv_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        autoscan_en = 1'b0;
    logic [1:0]  seq_code = 2'd0;
    logic [1:0]  single_sel = 2'd0;
    logic [63:0] settle_counts;
    logic [63:0] conv_counts;
    logic        drdy_clr = 1'b0;
    logic [1:0]  chan_idx;
    logic        settle_en;
    logic        conv_en;
    logic        eoc_pulse;
    logic [1:0]  eoc_chan;
    logic        drdy;

    localparam int SWL = 8 + 5;

    typedef struct packed {
        logic [1:0]  ch;
        logic [31:0] delta;
        logic        last;
    } item_t;

    item_t       exp_q[$];
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    int          last_t = 0;
    logic        drdy_exp = 1'b0;
    logic        pend = 1'b0;
    logic        done = 1'b0;

    conv_sequencer i_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .autoscan_en(autoscan_en),
        .seq_code(seq_code), .single_sel(single_sel),
        .settle_counts(settle_counts), .conv_counts(conv_counts),
        .drdy_clr(drdy_clr), .chan_idx(chan_idx), .settle_en(settle_en),
        .conv_en(conv_en), .eoc_pulse(eoc_pulse), .eoc_chan(eoc_chan), .drdy(drdy)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ls(input int c);
        return int'(settle_counts[c*16 +: 16]) * 16;
    endfunction
    function automatic int lc(input int c);
        return int'(conv_counts[c*16 +: 16]) * 16 + 4;
    endfunction
    function automatic int lastch(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 3;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: compares each strobe with the head of the queue.
    always @(negedge clk) begin
        if (pend) begin
            check("R8 drdy after strobe", int'(drdy), int'(drdy_exp));
            pend = 1'b0;
        end
        if (rst_n && eoc_pulse) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected strobe", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check("R1/R2 strobe channel", int'(eoc_chan), int'(it.ch));
                check("R4/R5/R6 strobe spacing", cyc - last_t, int'(it.delta));
                check("R7 conv_en at strobe", int'(conv_en), 1);
                last_t = cyc;
                if (it.last) drdy_exp = 1'b1;
                pend = 1'b1;
            end
        end
    end

    // Queues n expected strobes for one mode, starting from idle.
    task automatic push_run(input logic au, input logic [1:0] sq, input logic [1:0] sel, input int n);
        int c;
        item_t it;
        c = au ? 0 : int'(sel);
        for (int k = 0; k < n; k++) begin
            it.ch    = 2'(c);
            it.delta = 32'((k == 0 ? 0 : SWL) + ls(c) + lc(c));
            it.last  = !au || (c == lastch(sq));
            exp_q.push_back(it);
            if (au) c = (c >= lastch(sq)) ? 0 : c + 1;
        end
    endtask

    task automatic start_run;
        @(negedge clk);
        enable = 1'b1;
        last_t = cyc;
    endtask

    task automatic wait_empty;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Disables and checks idle outputs, then clears the flag.
    task automatic stop_and_clear(input string tag);
        enable = 1'b0;
        @(negedge clk);
        check({"R9 idle windows ", tag}, int'(settle_en) + int'(conv_en) + int'(eoc_pulse), 0);
        check({"R9 idle channel ", tag}, int'(chan_idx), 0);
        check({"R8 flag held ", tag}, int'(drdy), int'(drdy_exp));
        drdy_clr = 1'b1;
        @(negedge clk);
        drdy_clr = 1'b0;
        check({"R8 flag cleared ", tag}, int'(drdy), 0);
        drdy_exp = 1'b0;
    endtask

    initial begin
        int s;
        int c;
        int w;
        // Settle counts 1,2,0,3 and conversion counts 0,1,2,1 for ch0..ch3.
        settle_counts = {16'd3, 16'd0, 16'd2, 16'd1};
        conv_counts   = {16'd1, 16'd2, 16'd1, 16'd0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: outputs after reset.
        check("R11 reset outputs",
              int'(chan_idx) + int'(settle_en) + int'(conv_en) + int'(eoc_pulse) + int'(eoc_chan) + int'(drdy), 0);

        // R1: single channel, ch2 (zero settle).
        autoscan_en = 1'b0; single_sel = 2'd2;
        push_run(1'b0, 2'd0, 2'd2, 3);
        start_run(); wait_empty(); stop_and_clear("single ch2");

        // R2: round-robin code 00.
        autoscan_en = 1'b1; seq_code = 2'b00;
        push_run(1'b1, 2'b00, 2'd0, 5);
        start_run(); wait_empty(); stop_and_clear("rr 00");

        // R2: round-robin code 01.
        seq_code = 2'b01;
        push_run(1'b1, 2'b01, 2'd0, 4);
        start_run(); wait_empty(); stop_and_clear("rr 01");

        // R2: round-robin code 10.
        seq_code = 2'b10;
        push_run(1'b1, 2'b10, 2'd0, 5);
        start_run(); wait_empty(); stop_and_clear("rr 10");

        // R3: reserved code 11 visits all four channels.
        seq_code = 2'b11;
        push_run(1'b1, 2'b11, 2'd0, 5);
        start_run(); wait_empty(); stop_and_clear("rr 11");

        // R9: a partial pass cut off restarts at ch0.
        seq_code = 2'b10;
        push_run(1'b1, 2'b10, 2'd0, 1);
        start_run(); wait_empty();
        enable = 1'b0;
        @(negedge clk);
        push_run(1'b1, 2'b10, 2'd0, 2);
        start_run(); wait_empty(); stop_and_clear("restart");

        // R10: retarget single_sel mid-dwell; the current dwell stays on ch1.
        autoscan_en = 1'b0; single_sel = 2'd1;
        begin
            item_t it;
            it.ch = 2'd1; it.delta = 32'(ls(1) + lc(1)); it.last = 1'b1; exp_q.push_back(it);
            it.ch = 2'd3; it.delta = 32'(SWL + ls(3) + lc(3)); exp_q.push_back(it);
            exp_q.push_back(it);
        end
        start_run();
        while (!settle_en) @(negedge clk);
        single_sel = 2'd3;
        check("R10 channel held mid-dwell", int'(chan_idx), 1);
        wait_empty(); stop_and_clear("retarget");

        // R4/R5/R6: phase lengths on ch3 (48 settle, 20 convert, 13 gap).
        single_sel = 2'd3;
        push_run(1'b0, 2'd0, 2'd3, 2);
        start_run();
        @(negedge clk);
        s = 0; c = 0; w = 0;
        while (settle_en) begin s++; @(negedge clk); end
        while (conv_en) begin c++; @(negedge clk); end
        while (!settle_en && !conv_en) begin w++; @(negedge clk); end
        check("R4 settle length", s, 48);
        check("R5 convert length", c, 20);
        check("R6 switch gap", w, SWL);
        wait_empty(); stop_and_clear("phases");

        // R8: clear coinciding with a setting strobe leaves the flag set.
        single_sel = 2'd0;
        push_run(1'b0, 2'd0, 2'd0, 1);
        start_run();
        while (!eoc_pulse) @(negedge clk);
        drdy_clr = 1'b1;
        @(negedge clk);
        drdy_clr = 1'b0;
        check("R8 set beats clear", int'(drdy), 1);
        wait_empty(); stop_and_clear("set vs clear");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule